// File: doc/BRIEF.md
# Soft-Start Reference Ramp Sequencer

This block produces the digital reference code that a switching regulator's loop follows at power-up. It also decides when the under-voltage protection is armed, when power-good is reported, and when the control loop may drive the low-side switch. The ramp starts only when every supply-good input is high and the inhibit input is low. The code then climbs linearly from zero to the programmed target over exactly 2^CNT_W clocks, which is 2048 at the default.

The low-side driver stays blocked for the control loop until the PWM stage reports that the high-side switch has begun switching. This keeps a pre-biased output from being pulled down at start-up. An over-voltage request is carried on a separate path, which can force the low-side switch on in any state. If a supply drops or inhibit is asserted, the sequencer abandons the ramp and starts again from zero.

Top module: `ss_ref_seq`

## Requirements
- R1: While rst_n is low, ref_code, uvp_en, pgood, ls_permit and ls_force are all 0, whatever the inputs are.
- R2: The ramp starts only when all supply_ok bits are 1 and inhibit is 0. With any supply_ok bit at 0, ref_code stays 0 and pgood stays 0.
- R3: Count k rising edges from the first edge that sees the start condition, for k from 1 to 2048. After edge k, ref_code equals floor(target_code*k/2048), so after edge 2048 it equals target_code. Once the ramp has ended, ref_code follows target_code with one clock of delay.
- R4: pgood goes to 1 on edge 2049, one clock after ref_code first equals the target. It stays 1 while the start condition holds.
- R5: uvp_en goes to 1 one clock after ref_code is first greater than or equal to uv_thresh_code during the ramp. If the ramp never reaches the threshold, uvp_en goes to 1 on the same edge as pgood. Once set, it stays 1 until an abort.
- R6: ls_permit is 0 during the ramp until hs_started is sampled at 1, and it goes to 1 one clock after that. If hs_started never comes, ls_permit goes to 1 together with pgood.
- R7: ls_force equals ovp_request delayed by one clock. This holds in every state, including idle and while ls_permit is 0.
- R8: One clock after any supply_ok bit falls or inhibit rises, ref_code, pgood, uvp_en and ls_permit are all 0. When the start condition returns, the ramp restarts from step 1.
- R9: hs_started has no effect while the sequencer is idle. A pulse seen during idle does not set ls_permit once the ramp starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | NSUP | One bit for each supply, 1 means above its turn-on threshold |
| inhibit | input | 1 | 1 holds the sequencer idle |
| target_code | input | REF_W | Programmed final reference code |
| uv_thresh_code | input | REF_W | Reference code at which under-voltage protection arms |
| hs_started | input | 1 | PWM stage reports that high-side switching has begun |
| ovp_request | input | 1 | Over-voltage protection asks for the low-side switch to be on |
| ref_code | output | REF_W | Reference code sent to the DAC |
| uvp_en | output | 1 | Under-voltage protection enable |
| pgood | output | 1 | Power-good release |
| ls_permit | output | 1 | Control loop may drive the low-side switch |
| ls_force | output | 1 | Protection forces the low-side switch on |

## Verification
Three events can land on the final ramp edge: the under-voltage arm, the power-good release and the fallback low-side permit. One vector provokes this by setting the threshold equal to the target, so the arm condition is first met by the very step that completes the ramp. Another vector sets the target below the threshold, which forces the end-of-ramp path. In both cases the bench expects uvp_en and pgood to rise on the same sampled cycle, 2049. A second collision is an over-voltage request during the ramp while ls_permit is still 0. The bench checks that ls_force rises while ls_permit stays 0.

// File: rtl/ss_ref_pkg.sv
package ss_ref_pkg;
  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_RAMP = 2'd1,
    SS_DONE = 2'd2
  } ss_state_e;
endpackage

// File: rtl/ss_seq_ctrl.sv
// Sequencer state and ramp step counter.
module ss_seq_ctrl
  import ss_ref_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_ok,
  output ss_state_e       state_q,
  output logic [CNT_W:0]  step_d,
  output logic            ramp_end
);
  localparam logic [CNT_W:0] STEP_FULL = {1'b1, {CNT_W{1'b0}}};

  ss_state_e      state_d;
  logic [CNT_W:0] step_q;
  logic           state_en;
  logic           step_en;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    if (!start_ok) begin
      state_d = SS_IDLE;
      step_d  = '0;
    end else begin
      unique case (state_q)
        SS_IDLE: begin
          state_d = SS_RAMP;
          step_d  = {{CNT_W{1'b0}}, 1'b1};
        end
        SS_RAMP: begin
          if (step_q == STEP_FULL) state_d = SS_DONE;
          else                     step_d  = step_q + 1'b1;
        end
        default: state_d = SS_DONE;
      endcase
    end
  end

  assign ramp_end = start_ok && (state_q == SS_RAMP) && (step_q == STEP_FULL);
  assign state_en = (state_d != state_q);
  assign step_en  = (step_d != step_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SS_IDLE;
      step_q  <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (step_en)  step_q  <= step_d;
    end
  end
endmodule

// File: rtl/ss_ramp_scale.sv
// Reference code = target * step / 2^CNT_W, registered.
module ss_ramp_scale #(
  parameter int REF_W = 8,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REF_W-1:0] target,
  input  logic [CNT_W:0]   step,
  output logic [REF_W-1:0] ref_q
);
  localparam int PW = REF_W + CNT_W;

  logic [PW-1:0]    prod;
  logic [REF_W-1:0] ref_d;
  logic             ref_en;

  always_comb begin
    prod   = PW'(target) * PW'(step);
    ref_d  = prod[PW-1:CNT_W];
    ref_en = (ref_d != ref_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_q <= '0;
    else if (ref_en) ref_q <= ref_d;
  end
endmodule

// File: rtl/ss_arm_latch.sv
// Sticky enable: set while active, cleared whenever inactive.
module ss_arm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic set,
  output logic q
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_d  = active && (q || set);
    q_en = (q_d != q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/ss_ref_seq.sv
module ss_ref_seq
  import ss_ref_pkg::*;
#(
  parameter int REF_W = 8,
  parameter int CNT_W = 11,
  parameter int NSUP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSUP-1:0]  supply_ok,
  input  logic             inhibit,
  input  logic [REF_W-1:0] target_code,
  input  logic [REF_W-1:0] uv_thresh_code,
  input  logic             hs_started,
  input  logic             ovp_request,
  output logic [REF_W-1:0] ref_code,
  output logic             uvp_en,
  output logic             pgood,
  output logic             ls_permit,
  output logic             ls_force
);
  ss_state_e      state_q;
  logic [CNT_W:0] step_d;
  logic           start_ok;
  logic           ramp_end;
  logic           active;
  logic           uv_set;
  logic           ls_set;

  assign start_ok = (&supply_ok) && !inhibit;
  assign active   = start_ok && (state_q != SS_IDLE);
  assign pgood    = (state_q == SS_DONE);
  assign uv_set   = (ref_code >= uv_thresh_code) || ramp_end;
  assign ls_set   = hs_started || ramp_end;

  ss_seq_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ok (start_ok),
    .state_q  (state_q),
    .step_d   (step_d),
    .ramp_end (ramp_end)
  );

  ss_ramp_scale #(.REF_W(REF_W), .CNT_W(CNT_W)) scale_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .target (target_code),
    .step   (step_d),
    .ref_q  (ref_code)
  );

  ss_arm_latch uv_arm_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .set    (uv_set),
    .q      (uvp_en)
  );

  ss_arm_latch ls_arm_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .set    (ls_set),
    .q      (ls_permit)
  );

  // Protection path to the low-side driver, independent of sequencing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ls_force <= 1'b0;
    else        ls_force <= ovp_request;
  end
endmodule

// File: rtl/ss_ref_seq_chk.sv
module ss_ref_seq_chk #(
  parameter int REF_W = 8,
  parameter int NSUP  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSUP-1:0]  supply_ok,
  input logic             inhibit,
  input logic [REF_W-1:0] target_code,
  input logic [REF_W-1:0] uv_thresh_code,
  input logic             hs_started,
  input logic             ovp_request,
  input logic [REF_W-1:0] ref_code,
  input logic             uvp_en,
  input logic             pgood,
  input logic             ls_permit,
  input logic             ls_force
);
  logic start_ok;
  assign start_ok = (&supply_ok) && !inhibit;

  p_done_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood && $past(pgood) && $stable(target_code)) |-> (ref_code == target_code));

  p_done_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (uvp_en && ls_permit));

  p_uv_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uvp_en) |-> (($past(ref_code) >= $past(uv_thresh_code)) || pgood));

  p_permit_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_permit) |-> ($past(hs_started) || pgood));

  p_force_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_request |=> ls_force);

  p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ok |=> ((ref_code == '0) && !pgood && !uvp_en && !ls_permit));
endmodule

bind ss_ref_seq ss_ref_seq_chk #(.REF_W(REF_W), .NSUP(NSUP)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .supply_ok      (supply_ok),
  .inhibit        (inhibit),
  .target_code    (target_code),
  .uv_thresh_code (uv_thresh_code),
  .hs_started     (hs_started),
  .ovp_request    (ovp_request),
  .ref_code       (ref_code),
  .uvp_en         (uvp_en),
  .pgood          (pgood),
  .ls_permit      (ls_permit),
  .ls_force       (ls_force)
);

// File: tb/ss_ref_seq_tb_top.sv
module ss_ref_seq_tb_top;
  localparam int TCK   = 10;
  localparam int REF_W = 8;
  localparam int CNT_W = 11;
  localparam int NSUP  = 3;
  localparam int NSTEP = 1 << CNT_W;

  typedef struct packed {
    logic [7:0]  tgt;
    logic [7:0]  thr;
    logic [11:0] hs_at;   // 0 = never
    logic        early;   // 1 = threshold reached before ramp end
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{8'd200, 8'd77,  12'd300,  1'b1},
    '{8'd255, 8'd0,   12'd1,    1'b1},
    '{8'd50,  8'd77,  12'd0,    1'b0},
    '{8'd128, 8'd128, 12'd1000, 1'b0},
    '{8'd0,   8'd0,   12'd0,    1'b1}
  };

  logic             clk;
  logic             rst_n;
  logic [NSUP-1:0]  supply_ok;
  logic             inhibit;
  logic [REF_W-1:0] target_code;
  logic [REF_W-1:0] uv_thresh_code;
  logic             hs_started;
  logic             ovp_request;
  logic [REF_W-1:0] ref_code;
  logic             uvp_en;
  logic             pgood;
  logic             ls_permit;
  logic             ls_force;

  int n_chk;
  int n_err;

  ss_ref_seq #(.REF_W(REF_W), .CNT_W(CNT_W), .NSUP(NSUP)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .inhibit(inhibit),
    .target_code(target_code), .uv_thresh_code(uv_thresh_code),
    .hs_started(hs_started), .ovp_request(ovp_request),
    .ref_code(ref_code), .uvp_en(uvp_en), .pgood(pgood),
    .ls_permit(ls_permit), .ls_force(ls_force)
  );

  initial clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int uv_step(int t, int th);
    for (int k = 1; k <= NSTEP; k++)
      if (((t * k) >> CNT_W) >= th) return k + 1;
    return NSTEP + 1;
  endfunction

  task automatic go_idle();
    inhibit    = 1'b1;
    hs_started = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_vec(vec_t v);
    int uvk;
    int bad_r, act_r, exp_r;
    int bad_p, act_p, exp_p;
    int bad_u, act_u, exp_u;
    int bad_l, act_l, exp_l;
    bad_r = 0; bad_p = 0; bad_u = 0; bad_l = 0;
    act_r = 0; exp_r = 0; act_p = 0; exp_p = 0;
    act_u = 0; exp_u = 0; act_l = 0; exp_l = 0;
    go_idle();
    target_code    = v.tgt;
    uv_thresh_code = v.thr;
    supply_ok      = '1;
    inhibit        = 1'b0;
    uvk = uv_step(int'(v.tgt), int'(v.thr));
    chk("R5 early-arm expectation", int'(uvk <= NSTEP), int'(v.early));
    for (int k = 1; k <= NSTEP + 1; k++) begin
      int er, ep, eu, el;
      @(negedge clk);
      er = (k <= NSTEP) ? ((int'(v.tgt) * k) >> CNT_W) : int'(v.tgt);
      ep = int'(k > NSTEP);
      eu = int'(k >= uvk);
      el = int'(((v.hs_at != 0) && (k >= int'(v.hs_at) + 1)) || (k > NSTEP));
      if (!bad_r && int'(ref_code) != er) begin bad_r = 1; act_r = int'(ref_code); exp_r = er; end
      if (!bad_p && int'(pgood) != ep)    begin bad_p = 1; act_p = int'(pgood);    exp_p = ep; end
      if (!bad_u && int'(uvp_en) != eu)   begin bad_u = 1; act_u = int'(uvp_en);   exp_u = eu; end
      if (!bad_l && int'(ls_permit) != el) begin bad_l = 1; act_l = int'(ls_permit); exp_l = el; end
      if (k == int'(v.hs_at)) hs_started = 1'b1;
    end
    chk("R3 ramp ref_code", act_r, exp_r);
    chk("R4 pgood timing",  act_p, exp_p);
    chk("R5 uvp_en timing", act_u, exp_u);
    chk("R6 ls_permit timing", act_l, exp_l);
    go_idle();
    chk("R8 inhibit clears ref", int'(ref_code), 0);
    chk("R8 inhibit clears pgood/uvp/permit", int'({pgood, uvp_en, ls_permit}), 0);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    rst_n          = 1'b0;
    supply_ok      = '1;
    inhibit        = 1'b0;
    target_code    = 8'd200;
    uv_thresh_code = 8'd10;
    hs_started     = 1'b1;
    ovp_request    = 1'b1;
    #(3 * TCK);
    // R1: reset holds every output low even with active inputs
    chk("R1 reset ref_code", int'(ref_code), 0);
    chk("R1 reset flags", int'({uvp_en, pgood, ls_permit, ls_force}), 0);
    @(negedge clk);
    ovp_request = 1'b0;
    inhibit     = 1'b1;
    hs_started  = 1'b0;
    rst_n       = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 5; i++) run_vec(VEC[i]);

    // R2: one supply missing, no ramp
    go_idle();
    target_code    = 8'd255;
    uv_thresh_code = 8'd0;
    supply_ok      = 3'b101;
    inhibit        = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2 partial supply ref_code", int'(ref_code), 0);
    chk("R2 partial supply pgood/uvp", int'({pgood, uvp_en}), 0);

    // R9: hs_started during idle is ignored
    supply_ok  = '1;
    inhibit    = 1'b1;
    hs_started = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 idle hs_started permit", int'(ls_permit), 0);
    inhibit    = 1'b0;
    hs_started = 1'b0;
    for (int k = 1; k <= 100; k++) begin
      @(negedge clk);
      if (k == 10) chk("R9 permit after idle hs pulse", int'(ls_permit), 0);
      if (k == 30) ovp_request = 1'b1;
      if (k == 31) begin
        chk("R7 ls_force during ramp", int'(ls_force), 1);
        chk("R7 force while permit low", int'(ls_permit), 0);
        ovp_request = 1'b0;
      end
      if (k == 32) chk("R7 ls_force released", int'(ls_force), 0);
      if (k == 50) hs_started = 1'b1;
    end
    chk("R3 mid-ramp ref_code", int'(ref_code), (255 * 100) >> CNT_W);
    chk("R5 uvp_en armed mid-ramp", int'(uvp_en), 1);
    chk("R6 permit after hs_started", int'(ls_permit), 1);

    // R8: supply loss mid-ramp
    supply_ok[1] = 1'b0;
    @(negedge clk);
    chk("R8 supply loss ref_code", int'(ref_code), 0);
    chk("R8 supply loss flags", int'({pgood, uvp_en, ls_permit}), 0);
    supply_ok  = '1;
    hs_started = 1'b0;
    repeat (20) @(negedge clk);
    chk("R8 restart from zero", int'(ref_code), (255 * 20) >> CNT_W);
    chk("R8 restart permit low", int'(ls_permit), 0);

    // R4/R8: finish ramp, then inhibit from the done state
    repeat (NSTEP + 1 - 20) @(negedge clk);
    chk("R4 pgood at end", int'(pgood), 1);
    chk("R3 ref at target", int'(ref_code), 255);
    target_code = 8'd180;
    @(negedge clk);
    chk("R3 ref follows target after ramp", int'(ref_code), 180);
    inhibit = 1'b1;
    @(negedge clk);
    chk("R8 inhibit from done ref", int'(ref_code), 0);
    chk("R8 inhibit from done flags", int'({pgood, uvp_en, ls_permit}), 0);

    // R7: protection path in idle
    ovp_request = 1'b1;
    @(negedge clk);
    chk("R7 ls_force in idle", int'(ls_force), 1);
    chk("R7 permit stays low in idle", int'(ls_permit), 0);
    ovp_request = 1'b0;
    @(negedge clk);
    chk("R7 ls_force drops", int'(ls_force), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule